// File: doc/BRIEF.md
# USB Host Endpoint Poll and NAK-Timeout Timer

This unit gives one endpoint of a USB host controller its sense of time. The controller supplies a start-of-frame strobe once per frame at full or low speed, or once per microframe at high speed. The unit counts those strobes against an 8-bit interval value that software writes into it.

For periodic endpoints, meaning interrupt and isochronous ones, the count sets how often a receive poll is due. The unit then emits a one-cycle request each time that many strobes have gone by. For bulk endpoints the same value instead limits how long a run of NAK handshakes may last. When that run has covered the limit, a sticky timeout flag is raised. If an interval value is not legal for the selected transfer type and speed, an error flag is raised and both outputs are held quiet.

How the 8-bit value is read depends on the mode. For interrupt endpoints below high speed, it is a plain frame count. In every other case it is an exponent m, and the period is 2^(m-1) strobes. Bulk values of 0 and 1 switch the timeout off.

Top module: `usb_ep_interval_timer`

## Requirements
- R1: After reset the interval register reads 0, and `poll_due`, `nak_timeout` and `rsv_err` are all low while the type is control.
- R2: The type code is 2'b11 for interrupt. With interrupt type and `hs_mode`=0, an interval m from 1 to 255 gives one `poll_due` every m ticks.
- R3: With interrupt type and `hs_mode`=1, an interval m from 1 to 16 gives one `poll_due` every 2^(m-1) ticks.
- R4: The type code is 2'b01 for isochronous. At either speed, m from 1 to 16 gives one `poll_due` every 2^(m-1) ticks.
- R5: `poll_due` is high for one clock, in the cycle after the tick that completes the period, and it repeats every period. While `ep_enable` is low, no poll is issued and the count stays at zero.
- R6: The type code is 2'b10 for bulk. With m from 2 to 16, `nak_timeout` rises on the 2^(m-1)-th tick of an open NAK run; a run opens with a `nak_seen` strobe. The flag stays high until `timeout_clr`.
- R7: For bulk, an interval of 0 or 1 never raises `nak_timeout` and is not an error.
- R8: An `ack_seen` strobe, a register write or `ep_enable` low closes the NAK run and clears its count.
- R9: A reserved value raises `rsv_err` and suppresses both poll and timeout. Reserved values are 0 for interrupt and isochronous, above 16 for high-speed interrupt and for isochronous, and above 16 for bulk.
- R10: A register write, or a change of type or of `hs_mode`, restarts the period count from zero.
- R11: The type code is 2'b00 for control. Control never polls, never times out and never flags an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ep_enable | input | 1 | Endpoint active |
| ivl_wr | input | 1 | Interval register write strobe |
| ivl_wdata | input | 8 | Interval write value |
| xfer_type | input | 2 | 00 control, 01 isochronous, 10 bulk, 11 interrupt |
| hs_mode | input | 1 | High-speed link (ticks are microframes) |
| sof_tick | input | 1 | One-cycle start-of-frame strobe |
| nak_seen | input | 1 | NAK handshake received |
| ack_seen | input | 1 | Data or ACK handshake received |
| timeout_clr | input | 1 | Clears the sticky timeout flag |
| interval_q | output | 8 | Interval register contents |
| poll_due | output | 1 | One-cycle poll request |
| nak_timeout | output | 1 | Sticky NAK timeout flag |
| rsv_err | output | 1 | Interval value reserved for current mode |

## Verification
The bench builds the unit with its default parameters: an 8-bit interval and an exponent ceiling of 16. These values keep the full range within reach of a test, including the largest period of 32768 microframes at m=16 and the 255-frame linear period. They also put the reserved boundary at 17, one step above the largest legal exponent. Bulk limits are tested at small exponents. The exponent-to-period path they use is the same one that the large periodic case exercises.

// File: rtl/usb_ep_interval_timer.sv
module usb_ep_interval_timer #(
  parameter int IVL_W   = 8,
  parameter int EXP_MAX = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ep_enable,
  input  logic             ivl_wr,
  input  logic [IVL_W-1:0] ivl_wdata,
  input  logic [1:0]       xfer_type,
  input  logic             hs_mode,
  input  logic             sof_tick,
  input  logic             nak_seen,
  input  logic             ack_seen,
  input  logic             timeout_clr,
  output logic [IVL_W-1:0] interval_q,
  output logic             poll_due,
  output logic             nak_timeout,
  output logic             rsv_err
);
  localparam int CW = (EXP_MAX > IVL_W) ? EXP_MAX : IVL_W;
  localparam logic [1:0] T_CTL = 2'b00, T_ISO = 2'b01, T_BLK = 2'b10, T_INT = 2'b11;
  localparam logic [IVL_W-1:0] M_MAX = IVL_W'(EXP_MAX);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [IVL_W-1:0] ivl;
  logic [CW-1:0]    cnt, ncnt, period;
  logic [1:0]       prev_type;
  logic             prev_hs, nak_run;

  wire is_int   = xfer_type == T_INT;
  wire is_iso   = xfer_type == T_ISO;
  wire is_blk   = xfer_type == T_BLK;
  wire periodic = is_int | is_iso;
  wire use_lin  = is_int & ~hs_mode;
  wire in_exp   = (ivl != '0) && (ivl <= M_MAX);
  wire cfg_ok   = use_lin ? (ivl != '0) :
                  periodic ? in_exp :
                  is_blk ? (ivl <= M_MAX) : 1'b1;
  wire nak_on   = is_blk && (ivl >= IVL_W'(2)) && (ivl <= M_MAX);
  wire restart  = ivl_wr | ~ep_enable | (xfer_type != prev_type) | (hs_mode != prev_hs);
  wire poll_go  = sof_tick & periodic & cfg_ok;
  wire nak_go   = sof_tick & (nak_run | nak_seen);
  wire to_set   = ~restart & ~ack_seen & nak_on & nak_go & (ncnt == period - ONE);

  assign period     = use_lin ? CW'(ivl) : (ONE << (ivl - IVL_W'(1)));
  assign interval_q = ivl;
  assign rsv_err    = ~cfg_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ivl       <= '0;
      prev_type <= T_CTL;
      prev_hs   <= 1'b0;
    end else begin
      if (ivl_wr) ivl <= ivl_wdata;
      prev_type <= xfer_type;
      prev_hs   <= hs_mode;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt      <= '0;
      poll_due <= 1'b0;
    end else begin
      poll_due <= 1'b0;
      if (restart)
        cnt <= '0;
      else if (poll_go) begin
        if (cnt == period - ONE) begin
          cnt      <= '0;
          poll_due <= 1'b1;
        end else
          cnt <= cnt + ONE;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ncnt    <= '0;
      nak_run <= 1'b0;
    end else if (restart | ack_seen | ~nak_on) begin
      ncnt    <= '0;
      nak_run <= 1'b0;
    end else if (to_set) begin
      ncnt    <= '0;
      nak_run <= 1'b0;
    end else begin
      if (nak_seen) nak_run <= 1'b1;
      if (nak_go)   ncnt    <= ncnt + ONE;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) nak_timeout <= 1'b0;
    else        nak_timeout <= to_set | (nak_timeout & ~timeout_clr);

  p_poll_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    poll_due |-> $past(sof_tick && ep_enable));
  p_poll_periodic_r11: assert property (@(posedge clk) disable iff (!rst_n)
    poll_due |-> $past(xfer_type == T_INT || xfer_type == T_ISO));
  p_rsv_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rsv_err) |-> (!poll_due && !$rose(nak_timeout)));
  p_nak_bulk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nak_timeout) |-> $past(xfer_type == T_BLK && ep_enable && sof_tick));
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(nak_timeout) && !$past(timeout_clr)) |-> nak_timeout);
  p_no_bulk_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nak_timeout) |-> ($past(interval_q) >= IVL_W'(2)));
endmodule

// File: tb/usb_ep_interval_timer_test.sv
module usb_ep_interval_timer_test;
  localparam real CLK = 8.0;
  logic clk = 0, rst_n = 0, ep_enable = 1, ivl_wr = 0, hs_mode = 0;
  logic sof_tick = 0, nak_seen = 0, ack_seen = 0, timeout_clr = 0;
  logic [7:0] ivl_wdata = 0, interval_q;
  logic [1:0] xfer_type = 2'b00;
  logic poll_due, nak_timeout, rsv_err;
  int checks = 0, fails = 0;

  always #(CLK/2) clk = ~clk;

  usb_ep_interval_timer uut (.clk, .rst_n, .ep_enable, .ivl_wr, .ivl_wdata, .xfer_type,
    .hs_mode, .sof_tick, .nak_seen, .ack_seen, .timeout_clr, .interval_q, .poll_due,
    .nak_timeout, .rsv_err);

  // {type[28:27], hs[26], m[25:18], period[17:1], err[0]}
  localparam int NV = 13;
  localparam logic [28:0] VEC [NV] = '{
    {2'b11, 1'b0, 8'd1,   17'd1,     1'b0},
    {2'b11, 1'b0, 8'd5,   17'd5,     1'b0},
    {2'b11, 1'b0, 8'd255, 17'd255,   1'b0},
    {2'b11, 1'b1, 8'd1,   17'd1,     1'b0},
    {2'b11, 1'b1, 8'd4,   17'd8,     1'b0},
    {2'b11, 1'b1, 8'd16,  17'd32768, 1'b0},
    {2'b01, 1'b0, 8'd3,   17'd4,     1'b0},
    {2'b01, 1'b1, 8'd7,   17'd64,    1'b0},
    {2'b11, 1'b0, 8'd0,   17'd0,     1'b1},
    {2'b11, 1'b1, 8'd17,  17'd0,     1'b1},
    {2'b01, 1'b0, 8'd0,   17'd0,     1'b1},
    {2'b01, 1'b1, 8'd20,  17'd0,     1'b1},
    {2'b00, 1'b0, 8'd9,   17'd0,     1'b0}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] m);
    @(negedge clk); ivl_wr = 1; ivl_wdata = m;
    @(negedge clk); ivl_wr = 0;
  endtask

  task automatic pulse_nak();
    @(negedge clk); nak_seen = 1;
    @(negedge clk); nak_seen = 0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack_seen = 1;
    @(negedge clk); ack_seen = 0;
  endtask

  task automatic tick(output logic p, output logic t);
    @(negedge clk); sof_tick = 1;
    @(negedge clk); sof_tick = 0;
    p = poll_due; t = nak_timeout;
  endtask

  task automatic ticks_to_poll(input int limit, output int n);
    logic p, t;
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      tick(p, t);
      if (p && n == 0) n = i;
    end
  endtask

  task automatic ticks_to_poll_stop(input int limit, output int n);
    logic p, t;
    n = 0;
    for (int i = 1; i <= limit && n == 0; i++) begin
      tick(p, t);
      if (p) n = i;
    end
  endtask

  task automatic ticks_to_to(input int limit, output int n, output int polls);
    logic p, t;
    n = 0; polls = 0;
    for (int i = 1; i <= limit; i++) begin
      tick(p, t);
      if (p) polls++;
      if (t && n == 0) n = i;
    end
  endtask

  task automatic setcfg(input logic [1:0] ty, input logic h, input logic [7:0] m);
    @(negedge clk); xfer_type = ty; hs_mode = h;
    wr(m);
  endtask

  initial begin
    #(CLK * 300000);
    fails++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n, pc;
    logic p, t;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(interval_q == 0, "R1", interval_q, 0);
    chk({poll_due, nak_timeout, rsv_err} == 3'b000, "R1", {poll_due, nak_timeout, rsv_err}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [16:0] per;
      per = VEC[v][17:1];
      setcfg(VEC[v][28:27], VEC[v][26], VEC[v][25:18]);
      chk(rsv_err == VEC[v][0], "R9", rsv_err, VEC[v][0]);
      if (per != 0) begin
        ticks_to_poll_stop(int'(per) + 2, n);
        chk(n == int'(per), VEC[v][28:27] == 2'b01 ? "R4" : (VEC[v][26] ? "R3" : "R2"), n, per);
        if (per <= 256) begin
          ticks_to_poll_stop(int'(per) + 2, n);
          chk(n == int'(per), "R5", n, per);
        end
      end else begin
        ticks_to_poll(40, n);
        chk(n == 0, VEC[v][28:27] == 2'b00 ? "R11" : "R9", n, 0);
      end
    end

    // R5: single-cycle pulse, and no poll while disabled
    setcfg(2'b11, 1'b0, 8'd3);
    ticks_to_poll_stop(5, n);
    @(negedge clk);
    chk(poll_due == 0, "R5", poll_due, 0);
    @(negedge clk); ep_enable = 0;
    ticks_to_poll(10, n);
    chk(n == 0, "R5", n, 0);
    @(negedge clk); ep_enable = 1;
    ticks_to_poll_stop(6, n);
    chk(n == 3, "R5", n, 3);

    // R10: type change and rewrite restart the count
    setcfg(2'b11, 1'b0, 8'd4);
    tick(p, t); tick(p, t);
    @(negedge clk); xfer_type = 2'b01;
    ticks_to_poll_stop(12, n);
    chk(n == 8, "R10", n, 8);
    setcfg(2'b11, 1'b0, 8'd5);
    tick(p, t); tick(p, t); tick(p, t);
    wr(8'd5);
    ticks_to_poll_stop(8, n);
    chk(n == 5, "R10", n, 5);
    setcfg(2'b11, 1'b0, 8'd4);
    tick(p, t); tick(p, t);
    @(negedge clk); hs_mode = 1;
    ticks_to_poll_stop(12, n);
    chk(n == 8, "R10", n, 8);

    // R6: bulk limit 4 (m=3), sticky, clear
    setcfg(2'b10, 1'b1, 8'd3);
    chk(rsv_err == 0, "R6", rsv_err, 0);
    pulse_nak();
    ticks_to_to(4, n, pc);
    chk(n == 4, "R6", n, 4);
    chk(pc == 0, "R6", pc, 0);
    ticks_to_to(5, n, pc);
    chk(nak_timeout == 1, "R6", nak_timeout, 1);
    @(negedge clk); timeout_clr = 1;
    @(negedge clk); timeout_clr = 0;
    chk(nak_timeout == 0, "R6", nak_timeout, 0);
    setcfg(2'b10, 1'b0, 8'd2);
    pulse_nak();
    ticks_to_to(3, n, pc);
    chk(n == 2, "R6", n, 2);
    @(negedge clk); timeout_clr = 1;
    @(negedge clk); timeout_clr = 0;

    // R8: ack, write and disable each clear the run
    setcfg(2'b10, 1'b1, 8'd3);
    pulse_nak(); tick(p, t); tick(p, t); tick(p, t);
    pulse_ack();
    pulse_nak();
    ticks_to_to(3, n, pc);
    chk(n == 0, "R8", n, 0);
    ticks_to_to(1, n, pc);
    chk(n == 1, "R8", n, 1);
    @(negedge clk); timeout_clr = 1;
    @(negedge clk); timeout_clr = 0;
    pulse_nak(); tick(p, t); tick(p, t); tick(p, t);
    wr(8'd3);
    ticks_to_to(6, n, pc);
    chk(n == 0, "R8", n, 0);
    pulse_nak(); tick(p, t); tick(p, t); tick(p, t);
    @(negedge clk); ep_enable = 0;
    @(negedge clk); ep_enable = 1;
    ticks_to_to(6, n, pc);
    chk(n == 0, "R8", n, 0);

    // R7: bulk 0 and 1 disable the timeout
    setcfg(2'b10, 1'b1, 8'd1);
    chk(rsv_err == 0, "R7", rsv_err, 0);
    pulse_nak();
    ticks_to_to(60, n, pc);
    chk(n == 0, "R7", n, 0);
    setcfg(2'b10, 1'b0, 8'd0);
    chk(rsv_err == 0, "R7", rsv_err, 0);
    pulse_nak();
    ticks_to_to(60, n, pc);
    chk(n == 0, "R7", n, 0);

    // R9: bulk reserved value
    setcfg(2'b10, 1'b1, 8'd17);
    chk(rsv_err == 1, "R9", rsv_err, 1);
    pulse_nak();
    ticks_to_to(70, n, pc);
    chk(n == 0 && pc == 0, "R9", n + pc, 0);

    // R11: control ignores NAK runs
    setcfg(2'b00, 1'b0, 8'd2);
    chk(rsv_err == 0, "R11", rsv_err, 0);
    pulse_nak();
    ticks_to_to(10, n, pc);
    chk(n == 0 && pc == 0, "R11", n + pc, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule